// File: doc/BRIEF.md
# Memory Command and Write-Data Rate Converter

This block sits between a memory controller clocked on a slow clock and a PHY clocked on a fast clock. The two clocks are phase-aligned, and the fast clock runs `RATIO` times faster. Each slow cycle the controller presents a wide bundle of `SLOW_PHASES` command slots. Each slot carries chip select, the three strobe lines, bank, address, the DRAM reset line, a write-enable flag, write data and a byte mask. The block hands this bundle to the fast domain, where `SLOW_PHASES / RATIO` slots are issued per fast cycle. Command slot `p` goes out in fast slice `p / FAST_PHASES`, on fast slot `p % FAST_PHASES`.

Write data is handled differently from commands. The data of a whole slow cycle is packed by concatenation into fast slots that are `RATIO` times wider, and these are issued in one fast slice. That slice is chosen by `WRITE_DELAY`, so that a fast-side write latency that is not a multiple of `RATIO` can still be met. The controller covers the whole slow cycles of the latency, and `WRITE_DELAY = (write_latency - 1) mod RATIO` covers the remainder.

Top module: `dfi_rate_converter`

## Requirements
- R1: From reset until the first slice of the first slow cycle captured after reset is issued, every fast slot shows chip select and the three strobes high, bank and address zero, reset line low, and write enable, data and mask zero.
- R2: Slow command slot `p` appears in fast slice `p / FAST_PHASES` on fast slot `p % FAST_PHASES`.
- R3: Slice `c` (0 ≤ c < RATIO) of the slow cycle captured at a slow clock edge is visible on the outputs in the fast cycle that begins `2 + c` fast edges after that slow edge.
- R4: A slow slot whose chip select is high (1) is issued as an idle slot. Its strobes are driven high and its bank and address zero, whatever values the controller placed on those fields.
- R5: The reset line of each slot follows the mapping of R2, and its value does not depend on chip select.
- R6: Fast data slot `j` is the concatenation of slow data slots `j*RATIO` to `j*RATIO+RATIO-1`, with the lowest-numbered slot in the least significant bits.
- R7: Fast mask slot `j` is packed from the slow mask slots in the same order as R6.
- R8: Packed data and mask for a slow cycle appear only in slice `WRITE_DELAY` of that cycle. In every other slice, data and mask are zero.
- R9: Fast write enable `j` is the OR of the slow write enables in slots `j*RATIO` to `j*RATIO+RATIO-1`. It is asserted only in slice `WRITE_DELAY`.
- R10: Back-to-back slow cycles produce an unbroken stream of slices with no gap or repeat. The fast slice counter restarts exactly when the previous slow cycle's last slice is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_slow | input | 1 | Controller-side clock |
| clk_fast | input | 1 | PHY-side clock, RATIO times faster, edge-aligned |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| s_cs_n | input | SLOW_PHASES | Chip select per slow slot, active low |
| s_ras_n | input | SLOW_PHASES | Row strobe per slow slot |
| s_cas_n | input | SLOW_PHASES | Column strobe per slow slot |
| s_we_n | input | SLOW_PHASES | Write strobe per slow slot |
| s_bank | input | SLOW_PHASES*BANK_W | Bank per slow slot |
| s_address | input | SLOW_PHASES*ADDR_W | Address per slow slot |
| s_reset_n | input | SLOW_PHASES | DRAM reset line per slow slot |
| s_wrdata_en | input | SLOW_PHASES | Write data enable per slow slot |
| s_wrdata | input | SLOW_PHASES*DATA_W | Write data per slow slot |
| s_wrdata_mask | input | SLOW_PHASES*DATA_W/8 | Byte mask per slow slot |
| f_cs_n | output | SLOW_PHASES/RATIO | Chip select per fast slot |
| f_ras_n | output | SLOW_PHASES/RATIO | Row strobe per fast slot |
| f_cas_n | output | SLOW_PHASES/RATIO | Column strobe per fast slot |
| f_we_n | output | SLOW_PHASES/RATIO | Write strobe per fast slot |
| f_bank | output | SLOW_PHASES/RATIO*BANK_W | Bank per fast slot |
| f_address | output | SLOW_PHASES/RATIO*ADDR_W | Address per fast slot |
| f_reset_n | output | SLOW_PHASES/RATIO | DRAM reset line per fast slot |
| f_wrdata_en | output | SLOW_PHASES/RATIO | Packed write enable per fast slot |
| f_wrdata | output | SLOW_PHASES*DATA_W | Packed write data, DATA_W*RATIO per fast slot |
| f_wrdata_mask | output | SLOW_PHASES*DATA_W/8 | Packed byte mask per fast slot |

## Verification
The hardest situation to reach from the ports is a continuous run of slow cycles in which the fast counter must restart exactly as the previous cycle's last slice leaves. In that run, idle slots carry junk strobe, bank and address values, and packed write data must land only in the delayed slice. The stimulus drives a fresh bundle on every slow edge with no idle gaps. Across the run, the chip-select pattern sweeps all sixteen combinations of the four slow slots, and the write enables and reset lines vary independently of chip select. Every fast cycle is then compared with a slice computed arithmetically from the slow cycle index, starting from the cycles held in reset.

// File: rtl/dfi_rc_pkg.sv
package dfi_rc_pkg;

  // Width of a counter that spans n states (at least one bit).
  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic bit is_pow2(input int unsigned n);
    return (n != 0) && ((n & (n - 1)) == 0);
  endfunction

endpackage

// File: rtl/dfi_rc_slow_capture.sv
// Registers the controller bundle once per slow cycle and flips a marker
// bit so the fast domain can see that a new bundle is present.
module dfi_rc_slow_capture #(
  parameter int SP = 4,
  parameter int AW = 16,
  parameter int BW = 3,
  parameter int DW = 16,
  parameter int MW = 2
) (
  input  logic             clk_slow,
  input  logic             rst_n,
  input  logic [SP-1:0]    in_cs_n,
  input  logic [SP-1:0]    in_ras_n,
  input  logic [SP-1:0]    in_cas_n,
  input  logic [SP-1:0]    in_we_n,
  input  logic [SP*BW-1:0] in_bank,
  input  logic [SP*AW-1:0] in_addr,
  input  logic [SP-1:0]    in_rst_n,
  input  logic [SP-1:0]    in_wen,
  input  logic [SP*DW-1:0] in_data,
  input  logic [SP*MW-1:0] in_mask,
  output logic [SP-1:0]    q_cs_n,
  output logic [SP-1:0]    q_ras_n,
  output logic [SP-1:0]    q_cas_n,
  output logic [SP-1:0]    q_we_n,
  output logic [SP*BW-1:0] q_bank,
  output logic [SP*AW-1:0] q_addr,
  output logic [SP-1:0]    q_rst_n,
  output logic [SP-1:0]    q_wen,
  output logic [SP*DW-1:0] q_data,
  output logic [SP*MW-1:0] q_mask,
  output logic             q_tog
);

  logic tog_d;

  always_comb begin
    tog_d = ~q_tog;
  end

  always_ff @(posedge clk_slow or negedge rst_n) begin
    if (!rst_n) begin
      q_cs_n  <= '1;
      q_ras_n <= '1;
      q_cas_n <= '1;
      q_we_n  <= '1;
      q_bank  <= '0;
      q_addr  <= '0;
      q_rst_n <= '0;
      q_wen   <= '0;
      q_data  <= '0;
      q_mask  <= '0;
      q_tog   <= 1'b0;
    end else begin
      q_cs_n  <= in_cs_n;
      q_ras_n <= in_ras_n;
      q_cas_n <= in_cas_n;
      q_we_n  <= in_we_n;
      q_bank  <= in_bank;
      q_addr  <= in_addr;
      q_rst_n <= in_rst_n;
      q_wen   <= in_wen;
      q_data  <= in_data;
      q_mask  <= in_mask;
      q_tog   <= tog_d;
    end
  end

endmodule

// File: rtl/dfi_rc_phase_timer.sv
// Fast-domain slice counter. A change of the slow marker bit starts a new
// slow cycle: the counter returns to slice 0 and the bundle is taken over.
module dfi_rc_phase_timer
  import dfi_rc_pkg::*;
#(
  parameter int RATIO = 2,
  parameter int CW    = 1
) (
  input  logic          clk_fast,
  input  logic          rst_n,
  input  logic          slow_tog,
  output logic          start,
  output logic          run,
  output logic [CW-1:0] cnt
);

  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

  logic          tog_seen;
  logic [CW-1:0] cnt_d;
  logic          run_d;

  assign start = slow_tog ^ tog_seen;

  always_comb begin
    cnt_d = cnt;
    if (start) begin
      cnt_d = '0;
    end else if (cnt != LAST) begin
      cnt_d = cnt + CW'(1);
    end
    run_d = run | start;
  end

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      tog_seen <= 1'b0;
      cnt      <= LAST;
      run      <= 1'b0;
    end else begin
      tog_seen <= slow_tog;
      cnt      <= cnt_d;
      run      <= run_d;
    end
  end

  // R10: a new slow cycle arrives exactly when the last slice is being issued
  slice_wrap_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (start && run) |-> (cnt == LAST));

  generate
    if (RATIO > 1) begin : g_multi
      // R10: one restart per slow period, never on consecutive fast cycles
      single_start_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
        start |=> !start);
    end
  endgenerate

endmodule

// File: rtl/dfi_rc_cmd_serializer.sv
// Holds one slow cycle of command slots and issues FP of them per fast cycle,
// forcing slots without chip select to the idle pattern.
module dfi_rc_cmd_serializer #(
  parameter int RATIO = 2,
  parameter int SP    = 4,
  parameter int AW    = 16,
  parameter int BW    = 3,
  parameter int CW    = 1
) (
  input  logic             clk_fast,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic [CW-1:0]    cnt,
  input  logic [SP-1:0]    s_cs_n,
  input  logic [SP-1:0]    s_ras_n,
  input  logic [SP-1:0]    s_cas_n,
  input  logic [SP-1:0]    s_we_n,
  input  logic [SP*BW-1:0] s_bank,
  input  logic [SP*AW-1:0] s_addr,
  input  logic [SP-1:0]    s_rst_n,
  output logic [SP/RATIO-1:0]    f_cs_n,
  output logic [SP/RATIO-1:0]    f_ras_n,
  output logic [SP/RATIO-1:0]    f_cas_n,
  output logic [SP/RATIO-1:0]    f_we_n,
  output logic [SP/RATIO*BW-1:0] f_bank,
  output logic [SP/RATIO*AW-1:0] f_addr,
  output logic [SP/RATIO-1:0]    f_rst_n
);

  localparam int FP = SP / RATIO;

  logic [SP-1:0]    h_cs_q,   h_cs_d;
  logic [SP-1:0]    h_ras_q,  h_ras_d;
  logic [SP-1:0]    h_cas_q,  h_cas_d;
  logic [SP-1:0]    h_we_q,   h_we_d;
  logic [SP*BW-1:0] h_bank_q, h_bank_d;
  logic [SP*AW-1:0] h_addr_q, h_addr_d;
  logic [SP-1:0]    h_rst_q,  h_rst_d;

  logic [FP-1:0]    o_cs_d, o_ras_d, o_cas_d, o_we_d, o_rst_d;
  logic [FP*BW-1:0] o_bank_d;
  logic [FP*AW-1:0] o_addr_d;

  function automatic int slot(input logic [CW-1:0] c, input int j);
    return int'(c) * FP + j;
  endfunction

  // Hold registers: load enable is the start of a slow cycle
  always_comb begin
    h_cs_d   = h_cs_q;
    h_ras_d  = h_ras_q;
    h_cas_d  = h_cas_q;
    h_we_d   = h_we_q;
    h_bank_d = h_bank_q;
    h_addr_d = h_addr_q;
    h_rst_d  = h_rst_q;
    if (start) begin
      h_cs_d   = s_cs_n;
      h_ras_d  = s_ras_n;
      h_cas_d  = s_cas_n;
      h_we_d   = s_we_n;
      h_bank_d = s_bank;
      h_addr_d = s_addr;
      h_rst_d  = s_rst_n;
    end
  end

  // Output registers: enable is run; slice chosen by the counter
  always_comb begin
    o_cs_d   = f_cs_n;
    o_ras_d  = f_ras_n;
    o_cas_d  = f_cas_n;
    o_we_d   = f_we_n;
    o_bank_d = f_bank;
    o_addr_d = f_addr;
    o_rst_d  = f_rst_n;
    if (run) begin
      for (int j = 0; j < FP; j++) begin
        if (h_cs_q[slot(cnt, j)]) begin
          o_cs_d[j]              = 1'b1;
          o_ras_d[j]             = 1'b1;
          o_cas_d[j]             = 1'b1;
          o_we_d[j]              = 1'b1;
          o_bank_d[j*BW +: BW]   = '0;
          o_addr_d[j*AW +: AW]   = '0;
        end else begin
          o_cs_d[j]              = 1'b0;
          o_ras_d[j]             = h_ras_q[slot(cnt, j)];
          o_cas_d[j]             = h_cas_q[slot(cnt, j)];
          o_we_d[j]              = h_we_q[slot(cnt, j)];
          o_bank_d[j*BW +: BW]   = h_bank_q[slot(cnt, j)*BW +: BW];
          o_addr_d[j*AW +: AW]   = h_addr_q[slot(cnt, j)*AW +: AW];
        end
        o_rst_d[j] = h_rst_q[slot(cnt, j)];
      end
    end
  end

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      h_cs_q   <= '1;
      h_ras_q  <= '1;
      h_cas_q  <= '1;
      h_we_q   <= '1;
      h_bank_q <= '0;
      h_addr_q <= '0;
      h_rst_q  <= '0;
      f_cs_n   <= '1;
      f_ras_n  <= '1;
      f_cas_n  <= '1;
      f_we_n   <= '1;
      f_bank   <= '0;
      f_addr   <= '0;
      f_rst_n  <= '0;
    end else begin
      h_cs_q   <= h_cs_d;
      h_ras_q  <= h_ras_d;
      h_cas_q  <= h_cas_d;
      h_we_q   <= h_we_d;
      h_bank_q <= h_bank_d;
      h_addr_q <= h_addr_d;
      h_rst_q  <= h_rst_d;
      f_cs_n   <= o_cs_d;
      f_ras_n  <= o_ras_d;
      f_cas_n  <= o_cas_d;
      f_we_n   <= o_we_d;
      f_bank   <= o_bank_d;
      f_addr   <= o_addr_d;
      f_rst_n  <= o_rst_d;
    end
  end

  // R1: before the first slice is issued every slot is idle and reset is held
  pre_run_quiet_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
    !run |-> ((&f_cs_n) && (f_rst_n == '0)));

  generate
    for (genvar j = 0; j < FP; j++) begin : g_idle
      // R4: a deselected fast slot never carries strobes, bank or address
      idle_fill_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
        f_cs_n[j] |-> (f_ras_n[j] && f_cas_n[j] && f_we_n[j] &&
                       (f_bank[j*BW +: BW] == '0) && (f_addr[j*AW +: AW] == '0)));
    end
  endgenerate

endmodule

// File: rtl/dfi_rc_wrdata_packer.sv
// Packs a slow cycle of write data into wide fast slots and issues the
// result in the single slice selected by WRITE_DELAY.
module dfi_rc_wrdata_packer #(
  parameter int RATIO       = 2,
  parameter int SP          = 4,
  parameter int DW          = 16,
  parameter int MW          = 2,
  parameter int WRITE_DELAY = 0,
  parameter int CW          = 1
) (
  input  logic                clk_fast,
  input  logic                rst_n,
  input  logic                start,
  input  logic                run,
  input  logic [CW-1:0]       cnt,
  input  logic [SP-1:0]       s_wen,
  input  logic [SP*DW-1:0]    s_data,
  input  logic [SP*MW-1:0]    s_mask,
  output logic [SP/RATIO-1:0] f_wen,
  output logic [SP*DW-1:0]    f_data,
  output logic [SP*MW-1:0]    f_mask
);

  localparam int FP  = SP / RATIO;
  localparam int FDW = DW * RATIO;
  localparam int FMW = MW * RATIO;
  localparam logic [CW-1:0] SLOT = CW'(WRITE_DELAY);

  logic [SP-1:0]    h_wen_q,  h_wen_d;
  logic [SP*DW-1:0] h_data_q, h_data_d;
  logic [SP*MW-1:0] h_mask_q, h_mask_d;

  logic [FP-1:0]     pk_wen;
  logic [FP*FDW-1:0] pk_data;
  logic [FP*FMW-1:0] pk_mask;

  logic              emit;
  logic [FP-1:0]     o_wen_d;
  logic [FP*FDW-1:0] o_data_d;
  logic [FP*FMW-1:0] o_mask_d;

  // Packing network: slow slot j*RATIO+i lands in lane i of fast slot j
  generate
    for (genvar j = 0; j < FP; j++) begin : g_slot
      assign pk_wen[j] = |h_wen_q[j*RATIO +: RATIO];
      for (genvar i = 0; i < RATIO; i++) begin : g_lane
        assign pk_data[j*FDW + i*DW +: DW] = h_data_q[(j*RATIO + i)*DW +: DW];
        assign pk_mask[j*FMW + i*MW +: MW] = h_mask_q[(j*RATIO + i)*MW +: MW];
      end
    end
  endgenerate

  always_comb begin
    h_wen_d  = h_wen_q;
    h_data_d = h_data_q;
    h_mask_d = h_mask_q;
    if (start) begin
      h_wen_d  = s_wen;
      h_data_d = s_data;
      h_mask_d = s_mask;
    end
  end

  always_comb begin
    emit     = run && (cnt == SLOT);
    o_wen_d  = '0;
    o_data_d = '0;
    o_mask_d = '0;
    if (emit) begin
      o_wen_d  = pk_wen;
      o_data_d = pk_data;
      o_mask_d = pk_mask;
    end
  end

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      h_wen_q  <= '0;
      h_data_q <= '0;
      h_mask_q <= '0;
      f_wen    <= '0;
      f_data   <= '0;
      f_mask   <= '0;
    end else begin
      h_wen_q  <= h_wen_d;
      h_data_q <= h_data_d;
      h_mask_q <= h_mask_d;
      f_wen    <= o_wen_d;
      f_data   <= o_data_d;
      f_mask   <= o_mask_d;
    end
  end

  // R8: outside the chosen slice the data lanes stay quiet
  quiet_slice_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (run && (cnt != SLOT)) |=> ((f_data == '0) && (f_mask == '0) && (f_wen == '0)));

  // R9: a write enable on the fast side only follows the chosen slice
  wen_slot_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (f_wen != '0) |-> ($past(run) && ($past(cnt) == SLOT)));

endmodule

// File: rtl/dfi_rate_converter.sv
module dfi_rate_converter
  import dfi_rc_pkg::*;
#(
  parameter int RATIO       = 2,
  parameter int SLOW_PHASES = 4,
  parameter int ADDR_W      = 16,
  parameter int BANK_W      = 3,
  parameter int DATA_W      = 16,
  parameter int WRITE_DELAY = 1
) (
  input  logic                            clk_slow,
  input  logic                            clk_fast,
  input  logic                            rst_n,
  input  logic [SLOW_PHASES-1:0]          s_cs_n,
  input  logic [SLOW_PHASES-1:0]          s_ras_n,
  input  logic [SLOW_PHASES-1:0]          s_cas_n,
  input  logic [SLOW_PHASES-1:0]          s_we_n,
  input  logic [SLOW_PHASES*BANK_W-1:0]   s_bank,
  input  logic [SLOW_PHASES*ADDR_W-1:0]   s_address,
  input  logic [SLOW_PHASES-1:0]          s_reset_n,
  input  logic [SLOW_PHASES-1:0]          s_wrdata_en,
  input  logic [SLOW_PHASES*DATA_W-1:0]   s_wrdata,
  input  logic [SLOW_PHASES*DATA_W/8-1:0] s_wrdata_mask,
  output logic [SLOW_PHASES/RATIO-1:0]        f_cs_n,
  output logic [SLOW_PHASES/RATIO-1:0]        f_ras_n,
  output logic [SLOW_PHASES/RATIO-1:0]        f_cas_n,
  output logic [SLOW_PHASES/RATIO-1:0]        f_we_n,
  output logic [SLOW_PHASES/RATIO*BANK_W-1:0] f_bank,
  output logic [SLOW_PHASES/RATIO*ADDR_W-1:0] f_address,
  output logic [SLOW_PHASES/RATIO-1:0]        f_reset_n,
  output logic [SLOW_PHASES/RATIO-1:0]        f_wrdata_en,
  output logic [SLOW_PHASES*DATA_W-1:0]       f_wrdata,
  output logic [SLOW_PHASES*DATA_W/8-1:0]     f_wrdata_mask
);

  localparam int SP = SLOW_PHASES;
  localparam int MW = DATA_W / 8;
  localparam int CW = int'(cnt_bits(RATIO));

  initial begin
    if (!is_pow2(RATIO) || (SLOW_PHASES % RATIO) != 0 ||
        WRITE_DELAY < 0 || WRITE_DELAY >= RATIO || (DATA_W % 8) != 0) begin
      $fatal(1, "dfi_rate_converter: unsupported parameter set");
    end
  end

  logic [SP-1:0]        c_cs_n, c_ras_n, c_cas_n, c_we_n, c_rst_n, c_wen;
  logic [SP*BANK_W-1:0] c_bank;
  logic [SP*ADDR_W-1:0] c_addr;
  logic [SP*DATA_W-1:0] c_data;
  logic [SP*MW-1:0]     c_mask;
  logic                 c_tog;

  logic          start;
  logic          run;
  logic [CW-1:0] cnt;

  dfi_rc_slow_capture #(
    .SP(SP), .AW(ADDR_W), .BW(BANK_W), .DW(DATA_W), .MW(MW)
  ) u_capture (
    .clk_slow (clk_slow),
    .rst_n    (rst_n),
    .in_cs_n  (s_cs_n),
    .in_ras_n (s_ras_n),
    .in_cas_n (s_cas_n),
    .in_we_n  (s_we_n),
    .in_bank  (s_bank),
    .in_addr  (s_address),
    .in_rst_n (s_reset_n),
    .in_wen   (s_wrdata_en),
    .in_data  (s_wrdata),
    .in_mask  (s_wrdata_mask),
    .q_cs_n   (c_cs_n),
    .q_ras_n  (c_ras_n),
    .q_cas_n  (c_cas_n),
    .q_we_n   (c_we_n),
    .q_bank   (c_bank),
    .q_addr   (c_addr),
    .q_rst_n  (c_rst_n),
    .q_wen    (c_wen),
    .q_data   (c_data),
    .q_mask   (c_mask),
    .q_tog    (c_tog)
  );

  dfi_rc_phase_timer #(
    .RATIO(RATIO), .CW(CW)
  ) u_timer (
    .clk_fast (clk_fast),
    .rst_n    (rst_n),
    .slow_tog (c_tog),
    .start    (start),
    .run      (run),
    .cnt      (cnt)
  );

  dfi_rc_cmd_serializer #(
    .RATIO(RATIO), .SP(SP), .AW(ADDR_W), .BW(BANK_W), .CW(CW)
  ) u_cmd (
    .clk_fast (clk_fast),
    .rst_n    (rst_n),
    .start    (start),
    .run      (run),
    .cnt      (cnt),
    .s_cs_n   (c_cs_n),
    .s_ras_n  (c_ras_n),
    .s_cas_n  (c_cas_n),
    .s_we_n   (c_we_n),
    .s_bank   (c_bank),
    .s_addr   (c_addr),
    .s_rst_n  (c_rst_n),
    .f_cs_n   (f_cs_n),
    .f_ras_n  (f_ras_n),
    .f_cas_n  (f_cas_n),
    .f_we_n   (f_we_n),
    .f_bank   (f_bank),
    .f_addr   (f_address),
    .f_rst_n  (f_reset_n)
  );

  dfi_rc_wrdata_packer #(
    .RATIO(RATIO), .SP(SP), .DW(DATA_W), .MW(MW),
    .WRITE_DELAY(WRITE_DELAY), .CW(CW)
  ) u_wr (
    .clk_fast (clk_fast),
    .rst_n    (rst_n),
    .start    (start),
    .run      (run),
    .cnt      (cnt),
    .s_wen    (c_wen),
    .s_data   (c_data),
    .s_mask   (c_mask),
    .f_wen    (f_wrdata_en),
    .f_data   (f_wrdata),
    .f_mask   (f_wrdata_mask)
  );

endmodule

// File: tb/dfi_rate_converter_test.sv
module dfi_rate_converter_test;

  localparam int CLK_PERIOD = 10;
  localparam int RATIO = 2;
  localparam int SP    = 4;
  localparam int FP    = SP / RATIO;
  localparam int AW    = 16;
  localparam int BW    = 3;
  localparam int DW    = 16;
  localparam int MW    = DW / 8;
  localparam int FDW   = DW * RATIO;
  localparam int FMW   = MW * RATIO;
  localparam int WD    = 1;
  localparam int NV    = 64;
  localparam int FIRST = 4;
  localparam int TOTAL = FIRST + 2 + NV * RATIO + 4;

  logic clk_slow, clk_fast, rst_n;
  logic [SP-1:0]    s_cs_n, s_ras_n, s_cas_n, s_we_n, s_reset_n, s_wrdata_en;
  logic [SP*BW-1:0] s_bank;
  logic [SP*AW-1:0] s_address;
  logic [SP*DW-1:0] s_wrdata;
  logic [SP*MW-1:0] s_wrdata_mask;
  logic [FP-1:0]    f_cs_n, f_ras_n, f_cas_n, f_we_n, f_reset_n, f_wrdata_en;
  logic [FP*BW-1:0] f_bank;
  logic [FP*AW-1:0] f_address;
  logic [SP*DW-1:0] f_wrdata;
  logic [SP*MW-1:0] f_wrdata_mask;

  int checks = 0;
  int fails  = 0;
  int ph     = 0;

  dfi_rate_converter #(
    .RATIO(RATIO), .SLOW_PHASES(SP), .ADDR_W(AW), .BANK_W(BW),
    .DATA_W(DW), .WRITE_DELAY(WD)
  ) uut (
    .clk_slow(clk_slow), .clk_fast(clk_fast), .rst_n(rst_n),
    .s_cs_n(s_cs_n), .s_ras_n(s_ras_n), .s_cas_n(s_cas_n), .s_we_n(s_we_n),
    .s_bank(s_bank), .s_address(s_address), .s_reset_n(s_reset_n),
    .s_wrdata_en(s_wrdata_en), .s_wrdata(s_wrdata), .s_wrdata_mask(s_wrdata_mask),
    .f_cs_n(f_cs_n), .f_ras_n(f_ras_n), .f_cas_n(f_cas_n), .f_we_n(f_we_n),
    .f_bank(f_bank), .f_address(f_address), .f_reset_n(f_reset_n),
    .f_wrdata_en(f_wrdata_en), .f_wrdata(f_wrdata), .f_wrdata_mask(f_wrdata_mask)
  );

  // Both clocks change in the same time step; slow rises every RATIO fast edges
  initial begin
    clk_fast = 1'b0;
    clk_slow = 1'b0;
    forever begin
      #(CLK_PERIOD / 2);
      clk_fast = 1'b1;
      if (ph == 0) clk_slow = 1'b1;
      else if (ph == RATIO / 2) clk_slow = 1'b0;
      ph = (ph + 1) % RATIO;
      #(CLK_PERIOD / 2);
      clk_fast = 1'b0;
    end
  end

  function automatic logic [31:0] mix(input int k, input int p, input int s);
    logic [31:0] x;
    x = 32'(k) * 32'h9E3779B1 + 32'(p) * 32'h85EBCA77 + 32'(s) * 32'hC2B2AE3D + 32'd1;
    x = x ^ (x >> 15);
    x = x * 32'h2C1B3C6D;
    x = x ^ (x >> 12);
    return x;
  endfunction

  function automatic logic fbit(input int k, input int p, input int s);
    logic [31:0] x;
    x = mix(k, p, s);
    return x[0];
  endfunction

  // Chip-select sweep: all 16 patterns of the four slots across the run
  function automatic logic [SP-1:0] gen_cs(input int k);
    return SP'(k ^ (k >> 4));
  endfunction

  function automatic logic gen_rst(input int k, input int p);
    logic [31:0] x;
    x = mix(k, p, 4);
    return (x[1:0] != 2'b00);
  endfunction

  task automatic drive(input int k);
    logic [31:0] x;
    s_cs_n = gen_cs(k);
    for (int p = 0; p < SP; p++) begin
      s_ras_n[p]     = fbit(k, p, 1);
      s_cas_n[p]     = fbit(k, p, 2);
      s_we_n[p]      = fbit(k, p, 3);
      s_reset_n[p]   = gen_rst(k, p);
      s_wrdata_en[p] = fbit(k, p, 8);
      x = mix(k, p, 5);  s_bank[p*BW +: BW]        = x[BW-1:0];
      x = mix(k, p, 6);  s_address[p*AW +: AW]     = x[AW-1:0];
      x = mix(k, p, 9);  s_wrdata[p*DW +: DW]      = x[DW-1:0];
      x = mix(k, p, 10); s_wrdata_mask[p*MW +: MW] = x[MW-1:0];
    end
  endtask

  task automatic compare(input string req, input string what, input int fe,
                         input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s fast edge %0d: actual %h expected %h", req, what, fe, act, exp);
    end
  endtask

  task automatic check_cycle(input int fe);
    logic [FP-1:0]     ecs, eras, ecas, ewe, erst, ewen;
    logic [FP*BW-1:0]  ebank;
    logic [FP*AW-1:0]  eaddr;
    logic [FP*FDW-1:0] edata;
    logic [FP*FMW-1:0] emask;
    logic [SP-1:0]     cs;
    logic [31:0]       x;
    int d, k, c, p;
    string tc, tr, tw, tm, te;
    d = fe - (FIRST + 2);
    ecs = '1; eras = '1; ecas = '1; ewe = '1; erst = '0; ewen = '0;
    ebank = '0; eaddr = '0; edata = '0; emask = '0;
    if (d < 0) begin
      // R1: reset state and the cycles before the first slice
      tc = "R1"; tr = "R1"; tw = "R1"; tm = "R1"; te = "R1";
    end else begin
      k = d / RATIO;
      c = d % RATIO;
      if (k >= NV) return;
      tc = "R2/R3/R4/R10"; tr = "R5"; tw = "R6/R8"; tm = "R7/R8"; te = "R9";
      cs = gen_cs(k);
      for (int j = 0; j < FP; j++) begin
        p = c * FP + j;
        erst[j] = gen_rst(k, p);
        if (!cs[p]) begin
          ecs[j]  = 1'b0;
          eras[j] = fbit(k, p, 1);
          ecas[j] = fbit(k, p, 2);
          ewe[j]  = fbit(k, p, 3);
          x = mix(k, p, 5); ebank[j*BW +: BW] = x[BW-1:0];
          x = mix(k, p, 6); eaddr[j*AW +: AW] = x[AW-1:0];
        end
        if (c == WD) begin
          for (int i = 0; i < RATIO; i++) begin
            ewen[j] = ewen[j] | fbit(k, j*RATIO + i, 8);
            x = mix(k, j*RATIO + i, 9);  edata[j*FDW + i*DW +: DW] = x[DW-1:0];
            x = mix(k, j*RATIO + i, 10); emask[j*FMW + i*MW +: MW] = x[MW-1:0];
          end
        end
      end
    end
    compare(tc, "strobes", fe, 128'({f_cs_n, f_ras_n, f_cas_n, f_we_n}),
            128'({ecs, eras, ecas, ewe}));
    compare(tc, "bank/address", fe, 128'({f_bank, f_address}), 128'({ebank, eaddr}));
    compare(tr, "reset_n", fe, 128'(f_reset_n), 128'(erst));
    compare(tw, "wrdata", fe, 128'(f_wrdata), 128'(edata));
    compare(tm, "wrdata_mask", fe, 128'(f_wrdata_mask), 128'(emask));
    compare(te, "wrdata_en", fe, 128'(f_wrdata_en), 128'(ewen));
  endtask

  initial begin
    rst_n = 1'b0;
    drive(500);
    for (int fe = 0; fe < TOTAL; fe++) begin
      @(negedge clk_fast);
      check_cycle(fe);
      if (fe == FIRST - 1) rst_n = 1'b1;
      if (fe >= FIRST - 1 && ((fe + 1) % RATIO) == 0) drive((fe + 1 - FIRST) / RATIO);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL R10 watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule